// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Cascade Outputs

A four-bit binary counter steered by two count strobes instead of a clock and a direction bit. A rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. Both strobes idle high. All state bits change together. The strobes are sampled as synchronous inputs on a system clock, and their rising edges are found inside the block.

A synchronous clear returns the count to zero. An active-low parallel load presets it from a four-bit data input. Two active-low terminal-count outputs copy the low phase of the relevant strobe:

- The carry output follows the up strobe while the count is fifteen.
- The borrow output follows the down strobe while the count is zero.

Wiring carry into the up strobe of the next stage, and borrow into its down strobe, chains stages into a wider up/down counter. The two stages in such a chain update on the same system clock edge.

A modulo-N divider comes from presetting a start value and reloading it when the chain's borrow pulses.

Top module: `dual_strobe_counter`

## Requirements
- R1: After rst_ni is released, count_o is 0 and carry_no and borrow_no are both 1 while both strobes are high.
- R2: A rising edge on up_i, with no rising edge on dn_i in the same cycle, increments count_o by one. The new value is visible after the next system clock edge. Counting up wraps from 15 to 0.
- R3: A rising edge on dn_i, with no rising edge on up_i in the same cycle, decrements count_o by one, visible after the next system clock edge. Counting down wraps from 0 to 15.
- R4: When up_i and dn_i rise in the same cycle, count_o holds.
- R5: clear_i high at a clock edge sets count_o to 0, whatever the values of load_ni and the strobes.
- R6: load_ni low (with clear_i low) at a clock edge copies data_i into count_o. Strobe edges seen while load_ni is low are discarded and have no later effect.
- R7: carry_no is 0 exactly while count_o is 15 and up_i is 0; otherwise it is 1. There is no clock delay.
- R8: borrow_no is 0 exactly while count_o is 0 and dn_i is 0; otherwise it is 1. There is no clock delay.
- R9: Two stages, with carry_no driving the next up_i and borrow_no driving the next dn_i, form an 8-bit up/down counter whose value is {high count, low count}. The last stage's carry_no goes low only at 255, and its borrow_no only at 0.
- R10: In a cycle with no strobe rising edge, no clear and no load, count_o is unchanged. This holds even while a strobe is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Up-count strobe; idles high, counts on rising edge |
| dn_i | input | 1 | Down-count strobe; idles high, counts on rising edge |
| load_ni | input | 1 | Parallel preset enable, active low |
| clear_i | input | 1 | Clear to zero, active high, highest priority |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| carry_no | output | 1 | Active-low overflow pulse, low while count is all ones and up_i is low |
| borrow_no | output | 1 | Active-low underflow pulse, low while count is zero and dn_i is low |

## Verification
The functions that can collide in one cycle are counting and presetting. A strobe edge can arrive while load or clear is active, and both strobes can rise together.

The bench provokes each collision on purpose:

- It releases a strobe while load_ni is still low, then checks that the loaded value survives with no extra step after load is released.
- It releases a strobe while clear_i is high, then checks for zero.
- It raises both strobes in the same cycle.

In the two-stage chain, a simultaneous release at a terminal low nibble still moves the high stage through the carry or borrow pulse. The reference model predicts that movement rather than excluding it.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_DEC,
    OP_LOAD,
    OP_CLEAR
  } op_e;
endpackage

// File: rtl/dsc_edge_det.sv
module dsc_edge_det #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE;
    else         prev_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/dsc_op_decode.sv
module dsc_op_decode
  import dsc_pkg::*;
(
  input  logic clear_i,
  input  logic load_ni,
  input  logic inc_i,
  input  logic dec_i,
  output op_e  op_o
);
  // priority: clear, load, single-direction count
  always_comb begin
    if (clear_i)              op_o = OP_CLEAR;
    else if (!load_ni)        op_o = OP_LOAD;
    else if (inc_i && !dec_i) op_o = OP_INC;
    else if (dec_i && !inc_i) op_o = OP_DEC;
    else                      op_o = OP_HOLD;
  end
endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q, count_d;

  always_comb begin
    unique case (op_i)
      OP_CLEAR: count_d = '0;
      OP_LOAD:  count_d = data_i;
      OP_INC:   count_d = count_q + ONE;
      OP_DEC:   count_d = count_q - ONE;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/dsc_terminal.sv
module dsc_terminal #(
  parameter int   WIDTH  = 4,
  parameter logic AT_MAX = 1'b1
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             strobe_i,
  output logic             flag_no
);
  logic at_term;

  generate
    if (AT_MAX) begin : g_max
      assign at_term = &count_i;
    end else begin : g_min
      assign at_term = ~|count_i;
    end
  endgenerate

  // pulse width tracks strobe low phase exactly
  assign flag_no = ~(at_term & ~strobe_i);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             load_ni,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam int               NSTB = 2;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL1 = '1;

  logic [NSTB-1:0] stb, rise;
  op_e             op;

  assign stb = {dn_i, up_i};

  generate
    for (genvar g = 0; g < NSTB; g++) begin : g_edge
      dsc_edge_det #(.IDLE(1'b1)) u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (stb[g]),
        .rise_o   (rise[g])
      );
    end
  endgenerate

  dsc_op_decode u_dec (
    .clear_i (clear_i),
    .load_ni (load_ni),
    .inc_i   (rise[0]),
    .dec_i   (rise[1]),
    .op_o    (op)
  );

  dsc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .data_i  (data_i),
    .count_o (count_o)
  );

  dsc_terminal #(.WIDTH(WIDTH), .AT_MAX(1'b1)) u_carry (
    .count_i  (count_o),
    .strobe_i (up_i),
    .flag_no  (carry_no)
  );

  dsc_terminal #(.WIDTH(WIDTH), .AT_MAX(1'b0)) u_borrow (
    .count_i  (count_o),
    .strobe_i (dn_i),
    .flag_no  (borrow_no)
  );

  // port-level checks; strobe edges re-derived from the pins
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0); // R5
  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_ni) |=> count_o == $past(data_i)); // R6
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && up_i && !$past(up_i) && !(dn_i && !$past(dn_i)))
    |=> count_o == $past(count_o) + ONE); // R2
  AST_DN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && dn_i && !$past(dn_i) && !(up_i && !$past(up_i)))
    |=> count_o == $past(count_o) - ONE); // R3
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && up_i && !$past(up_i) && dn_i && !$past(dn_i))
    |=> $stable(count_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && !(up_i && !$past(up_i)) && !(dn_i && !$past(dn_i)))
    |=> $stable(count_o)); // R10
  AST_CARRY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i || count_o != ALL1) |-> carry_no); // R7
  AST_BORROW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i || count_o != '0) |-> borrow_no); // R8
endmodule

// File: tb/dual_strobe_counter_tb.sv
`timescale 1ns/100ps
module dual_strobe_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up = 1'b1, dn = 1'b1, load_n = 1'b1, clear = 1'b0;
  logic [7:0] data = '0;
  logic [3:0] q_lo, q_hi;
  logic       c_lo, b_lo, c_hi, b_hi;
  logic [7:0] ref_cnt = '0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dual_strobe_counter #(.WIDTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn),
    .load_ni(load_n), .clear_i(clear), .data_i(data[3:0]),
    .count_o(q_lo), .carry_no(c_lo), .borrow_no(b_lo)
  );

  dual_strobe_counter #(.WIDTH(4)) dut_hi_i (
    .clk_i(clk), .rst_ni(rst_n), .up_i(c_lo), .dn_i(b_lo),
    .load_ni(load_n), .clear_i(clear), .data_i(data[7:4]),
    .count_o(q_hi), .carry_no(c_hi), .borrow_no(b_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_count(input string req);
    chk(req, int'({q_hi, q_lo}), int'(ref_cnt));
  endtask

  task automatic step_up();
    @(negedge clk) up = 1'b0;
    @(negedge clk);
    chk("R7 carry low nibble", int'(c_lo), (ref_cnt[3:0] == 4'hF) ? 0 : 1);
    chk("R9 chain carry", int'(c_hi), (ref_cnt == 8'hFF) ? 0 : 1);
    up = 1'b1;
    @(negedge clk);
    ref_cnt = ref_cnt + 8'd1;
    chk_count("R2/R9 up step");
  endtask

  task automatic step_dn();
    @(negedge clk) dn = 1'b0;
    @(negedge clk);
    chk("R8 borrow low nibble", int'(b_lo), (ref_cnt[3:0] == 4'h0) ? 0 : 1);
    chk("R9 chain borrow", int'(b_hi), (ref_cnt == 8'h00) ? 0 : 1);
    dn = 1'b1;
    @(negedge clk);
    ref_cnt = ref_cnt - 8'd1;
    chk_count("R3/R9 down step");
  endtask

  task automatic step_both();
    logic [3:0] lo, hi;
    lo = ref_cnt[3:0];
    hi = ref_cnt[7:4];
    @(negedge clk) begin up = 1'b0; dn = 1'b0; end
    @(negedge clk) begin up = 1'b1; dn = 1'b1; end
    @(negedge clk);
    // low stage holds; high stage still sees a carry or borrow pulse
    if (lo == 4'hF)      hi = hi + 4'd1;
    else if (lo == 4'h0) hi = hi - 4'd1;
    ref_cnt = {hi, lo};
    chk_count("R4 simultaneous rise");
  endtask

  task automatic do_load(input logic [7:0] d, input bit with_stb);
    @(negedge clk) begin load_n = 1'b0; data = d; if (with_stb) up = 1'b0; end
    @(negedge clk) up = 1'b1;
    @(negedge clk) load_n = 1'b1;
    @(negedge clk);
    ref_cnt = d;
    chk_count("R6 load, strobe ignored");
  endtask

  task automatic do_clear(input bit with_stb);
    @(negedge clk) begin clear = 1'b1; load_n = 1'b0; data = 8'hA5; if (with_stb) up = 1'b0; end
    @(negedge clk) up = 1'b1;
    @(negedge clk) begin clear = 1'b0; load_n = 1'b1; end
    @(negedge clk);
    ref_cnt = '0;
    chk_count("R5 clear wins");
  endtask

  task automatic idle(input int n, input bit hold_low);
    @(negedge clk) if (hold_low) up = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_count("R10 no edge no change");
    end
    // finishing a held-low strobe is a real up edge
    if (hold_low) begin
      up = 1'b1;
      @(negedge clk);
      ref_cnt = ref_cnt + 8'd1;
      chk_count("R2 after held strobe");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", int'({q_hi, q_lo}), 0);
    chk("R1 reset carry", int'(c_lo), 1);
    chk("R1 reset borrow", int'(b_lo), 1);

    // wrap corners
    do_load(8'hFE, 1'b0);
    step_up();
    step_up();
    step_dn();
    do_load(8'h0F, 1'b0);
    step_up();
    step_dn();

    // modulo-4 divider: preset 3, count down to underflow, reload
    for (int k = 0; k < 2; k++) begin
      do_load(8'h03, 1'b0);
      repeat (3) step_dn();
      step_dn();
    end

    do_load(8'h5F, 1'b1);
    do_clear(1'b1);
    idle(3, 1'b1);
    do_load(8'h10, 1'b0);
    step_both();
    do_load(8'h2F, 1'b0);
    step_both();

    for (int it = 0; it < 600; it++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: step_up();
        3, 4, 5: step_dn();
        6:       step_both();
        7:       do_load(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
        8:       if ($urandom_range(0, 3) == 0) do_clear(1'($urandom_range(0, 1)));
                 else step_up();
        default: idle(int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)));
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule